// File: doc/BRIEF.md
# Prefetch Hint Refill Dispatcher

This block sits beside the core's load path and turns software prefetch hints into cache line refill requests. A hint names an address, which cache should receive the line (instruction or data) and whether the line is expected to be reused soon (high or low temporal locality). The block asks the selected cache whether the line is already resident. If it is not, the block reserves one entry from a small pool of refill slots and sends a line fill request toward memory. The slot is released when the matching fill response comes back.

A hint is only advice. The block never stalls the core, never returns data, never writes a register and never reports an error. A hint is silently dropped in any of these cases: the line is already resident, a refill for the same line and cache is already in flight, or every slot is taken. Four event counters let the surrounding logic or a test compare the traffic against a model.

Top module: `pf_hint_dispatch`

## Requirements
- R1: `hintReady` is high in every cycle after reset, including when the pool is full, so the core is never held back.
- R2: In the cycle a hint is presented, `lookupValid`, `lookupAddr` and `lookupIcache` carry `hintValid`, `hintAddr` and `hintIcache`. `lookupHit` is sampled one cycle later. When it is 1, the hint takes no slot and `cntHit` increments.
- R3: A missing hint is merged and dropped when an occupied slot holds the same line (address bits above bit 5) for the same cache. No slot is taken, `cntMerge` increments, and no duplicate fill is issued.
- R4: A missing, unmerged hint that finds all SLOTS slots occupied is dropped. Only `cntFull` increments; no slot and no fill changes.
- R5: Otherwise the lowest-numbered free slot is taken, `cntAlloc` increments, and that slot's index is the `fillTag` of its fill request.
- R6: A fill request carries the line address with bits 5..0 zero, the hint's cache select and locality bit. Pending slots are issued one at a time, and the lowest-numbered pending slot goes first.
- R7: While `fillValid` is high and `fillReady` is low, `fillValid` stays high and every fill field stays unchanged.
- R8: A response (`rspValid`) whose `rspTag` names a slot with an issued fill frees that slot. A response naming a free slot, or a slot whose fill has not yet been accepted, has no effect.
- R9: Decision priority for a hint is: hit, then merge, then pool full, then allocate. Merge takes precedence over a full pool.
- R10: After reset all slots are free, `fillValid` and `lookupValid` are low and all four counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hintValid | input | 1 | A prefetch hint is presented |
| hintAddr | input | ADDR_W | Byte address of the hint |
| hintIcache | input | 1 | 1 = instruction cache, 0 = data cache |
| hintHighReuse | input | 1 | 1 = high temporal locality |
| hintReady | output | 1 | Always high; hints are never stalled |
| lookupValid | output | 1 | Residency lookup strobe |
| lookupAddr | output | ADDR_W | Address to look up |
| lookupIcache | output | 1 | Cache to look up |
| lookupHit | input | 1 | Line resident, returned one cycle after the lookup |
| fillValid | output | 1 | Fill request valid |
| fillReady | input | 1 | Memory accepts the fill request |
| fillAddr | output | ADDR_W | Line-aligned fill address |
| fillIcache | output | 1 | Destination cache of the fill |
| fillHighReuse | output | 1 | Locality bit for installing the line |
| fillTag | output | $clog2(SLOTS) | Slot index of the request |
| rspValid | input | 1 | Fill response arrives |
| rspTag | input | $clog2(SLOTS) | Slot index of the response |
| cntAlloc | output | CNT_W | Hints that took a slot |
| cntHit | output | CNT_W | Hints dropped on a residency hit |
| cntFull | output | CNT_W | Hints dropped on a full pool |
| cntMerge | output | CNT_W | Hints merged into an in-flight refill |

## Verification
The bench builds the block with SLOTS=4, ADDR_W=16 and CNT_W=16. The sweep draws its hint lines from only nine line values over two caches. This makes merges, full-pool drops and slot reuse after responses frequent, rather than rare corner cases. With four slots, every pool-occupancy state and every slot index as a fill tag is reached, as are responses naming free, pending and in-flight slots. All of these are compared against an arithmetic slot model kept in the bench.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Strobes from the control to the slot datapath, one cycle each.
  typedef struct packed {
    logic alloc;      // take lowest free slot for the stage-1 hint
    logic merge;      // hint matched an occupied slot
    logic dropHit;    // hint line already resident
    logic dropFull;   // no free slot
    logic launch;     // latch lowest pending slot as the current request
    logic issueDone;  // current request accepted by memory
    logic retire;     // response frees the tagged slot
  } pfStrobe_t;

endpackage

// File: rtl/pf_slot_store.sv
module pf_slot_store
  import pf_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int LINE_W = 42,
  parameter int CNT_W  = 32,
  parameter int TAG_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pfStrobe_t         strb,
  input  logic [LINE_W-1:0] s1Line,
  input  logic              s1Icache,
  input  logic              s1Reuse,
  input  logic [TAG_W-1:0]  rspTag,
  output logic              matchAny,
  output logic              freeAny,
  output logic              pendAny,
  output logic              rspLive,
  output logic [TAG_W-1:0]  issueTag,
  output logic [LINE_W-1:0] fillLine,
  output logic              fillIcache,
  output logic              fillReuse,
  output logic [CNT_W-1:0]  cntAlloc,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntFull,
  output logic [CNT_W-1:0]  cntMerge
);

  logic [SLOTS-1:0]  slotValid;
  logic [SLOTS-1:0]  slotIssued;
  logic [SLOTS-1:0]  slotIcache;
  logic [SLOTS-1:0]  slotReuse;
  logic [LINE_W-1:0] slotLine [SLOTS];
  logic [SLOTS-1:0]  matchVec;
  logic [SLOTS-1:0]  pendVec;
  logic [TAG_W-1:0]  freeIdx;
  logic [TAG_W-1:0]  pendIdx;
  logic [TAG_W-1:0]  issueTagQ;

  function automatic logic [TAG_W-1:0] lowestSet(input logic [SLOTS-1:0] v);
    logic [TAG_W-1:0] idx;
    idx = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (v[k]) idx = TAG_W'(k);
    end
    return idx;
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : gMatch
    assign matchVec[g] = slotValid[g] && (slotLine[g] == s1Line) && (slotIcache[g] == s1Icache);
  end

  assign pendVec  = slotValid & ~slotIssued;
  assign matchAny = |matchVec;
  assign freeAny  = ~&slotValid;
  assign pendAny  = |pendVec;
  assign freeIdx  = lowestSet(~slotValid);
  assign pendIdx  = lowestSet(pendVec);
  assign rspLive  = slotValid[rspTag] & slotIssued[rspTag];

  assign issueTag   = issueTagQ;
  assign fillLine   = slotLine[issueTagQ];
  assign fillIcache = slotIcache[issueTagQ];
  assign fillReuse  = slotReuse[issueTagQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotValid  <= '0;
      slotIssued <= '0;
      slotIcache <= '0;
      slotReuse  <= '0;
      issueTagQ  <= '0;
      cntAlloc   <= '0;
      cntHit     <= '0;
      cntFull    <= '0;
      cntMerge   <= '0;
      for (int k = 0; k < SLOTS; k++) slotLine[k] <= '0;
    end else begin
      if (strb.alloc) begin
        slotValid[freeIdx]  <= 1'b1;
        slotIssued[freeIdx] <= 1'b0;
        slotLine[freeIdx]   <= s1Line;
        slotIcache[freeIdx] <= s1Icache;
        slotReuse[freeIdx]  <= s1Reuse;
      end
      if (strb.launch)    issueTagQ <= pendIdx;
      if (strb.issueDone) slotIssued[issueTagQ] <= 1'b1;
      if (strb.retire) begin
        slotValid[rspTag]  <= 1'b0;
        slotIssued[rspTag] <= 1'b0;
      end
      if (strb.alloc)    cntAlloc <= cntAlloc + 1'b1;
      if (strb.dropHit)  cntHit   <= cntHit + 1'b1;
      if (strb.dropFull) cntFull  <= cntFull + 1'b1;
      if (strb.merge)    cntMerge <= cntMerge + 1'b1;
    end
  end

  // Checker logic: two occupied slots must never hold the same line and cache.
  logic dupAny;
  always_comb begin
    dupAny = 1'b0;
    for (int a = 0; a < SLOTS; a++) begin
      for (int b = a + 1; b < SLOTS; b++) begin
        if (slotValid[a] && slotValid[b] && slotLine[a] == slotLine[b] &&
            slotIcache[a] == slotIcache[b]) dupAny = 1'b1;
      end
    end
  end

  assert_no_duplicate_R3: assert property (@(posedge clk) disable iff (!rst_n) !dupAny);

  assert_alloc_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc && !strb.retire |=> $countones(slotValid) == $past($countones(slotValid)) + 1);

  assert_retire_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.retire |=> !slotValid[$past(rspTag)]);

  assert_launch_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.launch |=> !slotIssued[issueTagQ] && slotValid[issueTagQ]);

endmodule

// File: rtl/pf_hint_ctrl.sv
module pf_hint_ctrl
  import pf_pkg::*;
#(
  parameter int LINE_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hintValid,
  input  logic [LINE_W-1:0] hintLine,
  input  logic              hintIcache,
  input  logic              hintReuse,
  input  logic              lookupHit,
  input  logic              fillReady,
  input  logic              rspValid,
  input  logic              matchAny,
  input  logic              freeAny,
  input  logic              pendAny,
  input  logic              rspLive,
  output pfStrobe_t         strb,
  output logic [LINE_W-1:0] s1Line,
  output logic              s1Icache,
  output logic              s1Reuse,
  output logic              fillValid
);

  logic s1Valid;
  logic busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s1Line   <= '0;
      s1Icache <= 1'b0;
      s1Reuse  <= 1'b0;
    end else begin
      s1Valid <= hintValid;
      if (hintValid) begin
        s1Line   <= hintLine;
        s1Icache <= hintIcache;
        s1Reuse  <= hintReuse;
      end
    end
  end

  always_comb begin
    strb = '0;
    if (s1Valid) begin
      if (lookupHit)     strb.dropHit  = 1'b1;
      else if (matchAny) strb.merge    = 1'b1;
      else if (!freeAny) strb.dropFull = 1'b1;
      else               strb.alloc    = 1'b1;
    end
    strb.launch    = !busy && pendAny;
    strb.issueDone = busy && fillReady;
    strb.retire    = rspValid && rspLive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              busy <= 1'b0;
    else if (strb.launch)    busy <= 1'b1;
    else if (strb.issueDone) busy <= 1'b0;
  end

  assign fillValid = busy;

endmodule

// File: rtl/pf_hint_dispatch.sv
module pf_hint_dispatch
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 64,
  parameter int SLOTS      = 4,
  parameter int CNT_W      = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int TAG_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hintValid,
  input  logic [ADDR_W-1:0] hintAddr,
  input  logic              hintIcache,
  input  logic              hintHighReuse,
  output logic              hintReady,
  output logic              lookupValid,
  output logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupIcache,
  input  logic              lookupHit,
  output logic              fillValid,
  input  logic              fillReady,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              fillIcache,
  output logic              fillHighReuse,
  output logic [TAG_W-1:0]  fillTag,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag,
  output logic [CNT_W-1:0]  cntAlloc,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntFull,
  output logic [CNT_W-1:0]  cntMerge
);

  pfStrobe_t         strb;
  logic [LINE_W-1:0] s1Line;
  logic              s1Icache;
  logic              s1Reuse;
  logic              matchAny;
  logic              freeAny;
  logic              pendAny;
  logic              rspLive;
  logic [LINE_W-1:0] fillLine;

  assign hintReady    = 1'b1;
  assign lookupValid  = hintValid;
  assign lookupAddr   = hintAddr;
  assign lookupIcache = hintIcache;
  assign fillAddr     = {fillLine, {OFF_W{1'b0}}};

  pf_hint_ctrl #(.LINE_W(LINE_W)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hintValid  (hintValid),
    .hintLine   (hintAddr[ADDR_W-1:OFF_W]),
    .hintIcache (hintIcache),
    .hintReuse  (hintHighReuse),
    .lookupHit  (lookupHit),
    .fillReady  (fillReady),
    .rspValid   (rspValid),
    .matchAny   (matchAny),
    .freeAny    (freeAny),
    .pendAny    (pendAny),
    .rspLive    (rspLive),
    .strb       (strb),
    .s1Line     (s1Line),
    .s1Icache   (s1Icache),
    .s1Reuse    (s1Reuse),
    .fillValid  (fillValid)
  );

  pf_slot_store #(.SLOTS(SLOTS), .LINE_W(LINE_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) uStore (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .s1Line     (s1Line),
    .s1Icache   (s1Icache),
    .s1Reuse    (s1Reuse),
    .rspTag     (rspTag),
    .matchAny   (matchAny),
    .freeAny    (freeAny),
    .pendAny    (pendAny),
    .rspLive    (rspLive),
    .issueTag   (fillTag),
    .fillLine   (fillLine),
    .fillIcache (fillIcache),
    .fillReuse  (fillHighReuse),
    .cntAlloc   (cntAlloc),
    .cntHit     (cntHit),
    .cntFull    (cntFull),
    .cntMerge   (cntMerge)
  );

  assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid && !fillReady |=> fillValid && $stable(fillTag) && $stable(fillAddr) &&
                                $stable(fillIcache) && $stable(fillHighReuse));

  assert_hit_no_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hintValid) && lookupHit |-> !strb.alloc && !strb.merge && !strb.dropFull);

endmodule

// File: tb/sim_pf_hint_dispatch.sv
`timescale 1ns/1ps
module sim_pf_hint_dispatch;

  localparam int AW = 16;
  localparam int NS = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hintValid = 1'b0;
  logic [AW-1:0] hintAddr = '0;
  logic          hintIcache = 1'b0;
  logic          hintHighReuse = 1'b0;
  logic          hintReady;
  logic          lookupValid;
  logic [AW-1:0] lookupAddr;
  logic          lookupIcache;
  logic          lookupHit = 1'b0;
  logic          fillValid;
  logic          fillReady = 1'b0;
  logic [AW-1:0] fillAddr;
  logic          fillIcache;
  logic          fillHighReuse;
  logic [1:0]    fillTag;
  logic          rspValid = 1'b0;
  logic [1:0]    rspTag = '0;
  logic [CW-1:0] cntAlloc, cntHit, cntFull, cntMerge;

  always #4 clk = ~clk;

  pf_hint_dispatch #(.ADDR_W(AW), .LINE_BYTES(64), .SLOTS(NS), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hintValid(hintValid), .hintAddr(hintAddr),
    .hintIcache(hintIcache), .hintHighReuse(hintHighReuse), .hintReady(hintReady),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .lookupIcache(lookupIcache),
    .lookupHit(lookupHit), .fillValid(fillValid), .fillReady(fillReady),
    .fillAddr(fillAddr), .fillIcache(fillIcache), .fillHighReuse(fillHighReuse),
    .fillTag(fillTag), .rspValid(rspValid), .rspTag(rspTag), .cntAlloc(cntAlloc),
    .cntHit(cntHit), .cntFull(cntFull), .cntMerge(cntMerge)
  );

  int checkCount = 0;
  int failCount  = 0;

  // Reference slot model
  bit       mValid [NS];
  bit       mIss   [NS];
  bit [9:0] mLine  [NS];
  bit       mIc    [NS];
  bit       mRe    [NS];
  int expAlloc = 0, expHit = 0, expFull = 0, expMerge = 0;
  int fillsSeen = 0;
  int lastTag = -1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  function automatic int lowestPending();
    for (int k = 0; k < NS; k++) if (mValid[k] && !mIss[k]) return k;
    return -1;
  endfunction

  // Fill monitor: checks every accepted request against the model (R6, R7)
  logic holdPrev = 1'b0;
  logic [1:0] holdTag;
  logic [AW-1:0] holdAddr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (holdPrev) begin
        chk("R7", {fillValid, fillTag, fillAddr}, {1'b1, holdTag, holdAddr}, "held request");
      end
      holdPrev = fillValid && !fillReady;
      holdTag  = fillTag;
      holdAddr = fillAddr;
      if (fillValid && fillReady) begin
        int t;
        t = int'(fillTag);
        chk("R6", t, lowestPending(), "fill tag order");
        chk("R6", {mValid[t], mIss[t]}, 2'b10, "tagged slot pending");
        chk("R6", fillAddr, {mLine[t], 6'b0}, "fill address");
        chk("R6", {fillIcache, fillHighReuse}, {mIc[t], mRe[t]}, "fill cache/locality");
        mIss[t] = 1'b1;
        fillsSeen++;
        lastTag = t;
      end
    end
  end

  task automatic checkCounters(input string req);
    chk(req, cntAlloc, expAlloc, "cntAlloc");
    chk(req, cntHit,   expHit,   "cntHit");
    chk(req, cntFull,  expFull,  "cntFull");
    chk(req, cntMerge, expMerge, "cntMerge");
  endtask

  // Returns decision: 0 hit, 1 merge, 2 full, 3 alloc
  task automatic sendHint(input bit [9:0] line, input bit [5:0] off, input bit ic, input bit re,
                          input bit hit, input string req);
    int dec;
    int freeSlot;
    @(negedge clk);
    hintValid = 1'b1; hintAddr = {line, off}; hintIcache = ic; hintHighReuse = re;
    #1;
    chk("R2", {lookupValid, lookupIcache, lookupAddr}, {1'b1, ic, line, off}, "lookup mirror");
    @(negedge clk);
    hintValid = 1'b0; lookupHit = hit;
    dec = 3;
    freeSlot = -1;
    for (int k = NS - 1; k >= 0; k--) if (!mValid[k]) freeSlot = k;
    if (hit) dec = 0;
    else begin
      for (int k = 0; k < NS; k++) if (mValid[k] && mLine[k] == line && mIc[k] == ic) dec = 1;
      if (dec == 3 && freeSlot < 0) dec = 2;
    end
    case (dec)
      0: expHit++;
      1: expMerge++;
      2: expFull++;
      default: begin
        expAlloc++;
        mValid[freeSlot] = 1'b1; mIss[freeSlot] = 1'b0;
        mLine[freeSlot] = line; mIc[freeSlot] = ic; mRe[freeSlot] = re;
      end
    endcase
    @(negedge clk);
    lookupHit = 1'b0;
    chk("R1", hintReady, 1'b1, "hint ready");
    checkCounters(req);
    repeat (3) @(negedge clk);
  endtask

  task automatic respond(input int tag);
    @(negedge clk);
    rspValid = 1'b1; rspTag = 2'(tag);
    if (mValid[tag] && mIss[tag]) begin mValid[tag] = 1'b0; mIss[tag] = 1'b0; end
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin mValid[k] = 0; mIss[k] = 0; mLine[k] = 0; mIc[k] = 0; mRe[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R10", {fillValid, lookupValid, hintReady}, 3'b001, "reset outputs");
    chk("R10", {cntAlloc, cntHit, cntFull, cntMerge}, 64'd0, "reset counters");
    rst_n = 1'b1;
    @(negedge clk);

    // Fill the pool while memory is stalled (R5, R7)
    sendHint(10'h040, 6'h13, 1'b0, 1'b1, 1'b0, "R5");
    sendHint(10'h041, 6'h00, 1'b0, 1'b0, 1'b0, "R5");
    sendHint(10'h042, 6'h3f, 1'b1, 1'b1, 1'b0, "R5");
    sendHint(10'h043, 6'h01, 1'b1, 1'b0, 1'b0, "R5");
    chk("R5", {fillValid, fillTag}, {1'b1, 2'd0}, "first request tag");
    chk("R6", fillAddr, {10'h040, 6'h00}, "aligned address");
    repeat (4) @(negedge clk);
    chk("R7", {fillValid, fillTag}, {1'b1, 2'd0}, "request held");

    // Response for a pending, not yet issued slot is ignored (R8)
    respond(1);
    sendHint(10'h050, 6'h05, 1'b0, 1'b0, 1'b0, "R8");
    chk("R4", cntFull, 16'd1, "full drop after ignored response");
    // Same line, other cache: full (R4); same line, same cache: merge (R3, R9)
    sendHint(10'h041, 6'h22, 1'b1, 1'b0, 1'b0, "R4");
    sendHint(10'h041, 6'h22, 1'b0, 1'b1, 1'b0, "R3");
    sendHint(10'h041, 6'h22, 1'b0, 1'b1, 1'b1, "R9");
    chk("R9", {cntMerge, cntHit, cntFull}, {16'd1, 16'd1, 16'd2}, "priority order");

    // Release memory: four requests in slot order (R6)
    fillReady = 1'b1;
    repeat (12) @(negedge clk);
    chk("R6", fillsSeen, 4, "fills issued");
    chk("R6", fillValid, 1'b0, "no extra request");

    // Response to an unused tag is ignored, real one frees slot 2 (R8, R5)
    respond(2);
    sendHint(10'h060, 6'h07, 1'b0, 1'b1, 1'b0, "R5");
    repeat (2) @(negedge clk);
    chk("R5", lastTag, 2, "lowest free slot reused");
    respond(2);
    respond(2);
    respond(0);
    sendHint(10'h061, 6'h00, 1'b1, 1'b0, 1'b0, "R5");
    repeat (2) @(negedge clk);
    chk("R5", lastTag, 0, "slot 0 chosen over slot 2");

    // Sweep with a small line space: hits, merges, full drops and reuse
    for (int i = 0; i < 120; i++) begin
      sendHint(10'h020 + 10'((i * 7) % 9), 6'((i * 13) % 64), 1'(i / 3), 1'(i),
               (i % 5) == 4, "R9");
      if (i % 2 == 1) respond(i % 4);
      if (i % 7 == 6) respond((i + 1) % 4);
    end
    repeat (6) @(negedge clk);
    chk("R6", fillValid, 1'b0, "sweep drained");
    checkCounters("R3");
    chk("R4", (expFull > 0) && (expMerge > 0) && (expHit > 0), 1'b1, "sweep reached all drop kinds");
    finishRun();
  end

endmodule